// File: doc/BRIEF.md
# Bus Width Sizer and Wait-State Sequencer

This block sits between a processor-side request port with a 16-bit data path and an expansion bus on which both byte-wide and word-wide targets live. A request carries an address, two byte enables, a read/write flag and a memory/IO flag. The block runs a one-clock address phase with an address-latch pulse, then a command phase with the proper read or write strobe. The length of the command phase depends on the target width, which the block learns from two active-low "16-bit target" inputs (one for memory, one for IO) sampled while the address phase is on the bus.

A word access to a byte-wide target is split into two byte transfers: the low byte at the even address, then the high byte at the odd address. Data for a byte-wide target always travels on bits 7:0, so the high byte is steered between lanes in both directions, and a split read assembles both bytes before it reports completion. An active-high ready input that is held low stretches the command phase by whole clocks. An active-low early-finish input ends the command phase at once. A ready input held low for too long ends the access with an error flag, so the bus can never hang.

Top module: `bus_sizer`

## Requirements
- R1: After reset, busy_o, done_o, err_o and bale_o are low, all four strobes are high (inactive) and rdata_o is zero.
- R2: When the selected 16-bit target input is low while bale_o is high, the access completes in 3 clocks: 1 address clock and a command phase of WS16+1 = 2 clocks. done_o pulses for one clock in the following clock.
- R3: A byte-wide target (the selected 16-bit target input is high while bale_o is high) gets a command phase of WS8+1 = 5 clocks, so each byte transfer takes 6 clocks.
- R4: A word access (be_i = 2'b11) to a byte-wide target runs as two 6-clock transfers. The first is at the even byte address ({addr[23:1],0}) and the second at the odd one ({addr[23:1],1}). The access takes 12 clocks in total, with a single done_o pulse.
- R5: On a byte-wide target, both halves of bus_wdata_o carry the selected byte, and a read takes bits 7:0 of bus_rdata_i into the lane being transferred. On a 16-bit target, data passes on its natural lanes. rdata_o is cleared when a request is accepted and is valid with done_o. be_i = 2'b01 selects lane 0 (even address), be_i = 2'b10 selects lane 1 (odd address), and be_i = 2'b11 selects the word.
- R6: If rdy_i is low on the clock where the command phase would end, the phase is extended by one clock for each such clock.
- R7: If zws_ni is low (and rdy_i is high) on any command clock, the command phase ends on that clock.
- R8: If rdy_i is low on TMO_LIM consecutive end-point clocks, the transfer ends on the last of them. done_o and err_o then pulse together, and any second half still pending is dropped.
- R9: bale_o is high for exactly the one address clock of each transfer. No strobe is active during that clock, and bus_addr_o holds steady through the command phase.
- R10: At most one strobe is active at a time. The strobe is mem_rd_no, mem_wr_no, io_rd_no or io_wr_no, chosen by io_i and we_i.
- R11: bhe_no is low exactly when the access includes the high byte (be_i[1] = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request, accepted while idle |
| addr_i | input | AW | Byte address, bit 0 taken from be_i |
| be_i | input | 2 | Byte enables (01 low, 10 high, 11 word) |
| we_i | input | 1 | 1 = write |
| io_i | input | 1 | 1 = IO space, 0 = memory |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Ready timeout, pulses with done_o |
| rdata_o | output | 16 | Read data, valid with done_o |
| bus_addr_o | output | AW | Expansion bus byte address |
| bale_o | output | 1 | Address latch enable |
| bhe_no | output | 1 | High byte enable, active low |
| mem_rd_no | output | 1 | Memory read strobe, active low |
| mem_wr_no | output | 1 | Memory write strobe, active low |
| io_rd_no | output | 1 | IO read strobe, active low |
| io_wr_no | output | 1 | IO write strobe, active low |
| bus_wdata_o | output | 16 | Expansion bus write data |
| bus_rdata_i | input | 16 | Expansion bus read data |
| memcs16_ni | input | 1 | Memory target is 16-bit, active low |
| iocs16_ni | input | 1 | IO target is 16-bit, active low |
| zws_ni | input | 1 | Finish the command phase now, active low |
| rdy_i | input | 1 | Bus ready, low stretches the cycle |

## Verification
The assertions assume that requests never use be_i = 2'b00, and that the target-width inputs keep one value for the whole of an access, so a split word treats both halves as byte-wide. They also rely on the 16-bit wait count being no larger than the byte-wide one: the bound they place on the strobe length is WS8 + TMO_LIM clocks. The bench drives only these three enable codes, holds both width inputs fixed from request to completion, and drives the inactive-space width input to the opposite level to expose a wrong selection. It changes rdy_i and zws_ni only on command clocks that its own model has placed.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_CMD} bsz_state_e;

  // active-low strobe vector {mem_rd, mem_wr, io_rd, io_wr}
  function automatic logic [3:0] strobe_vec(input logic cmd, input logic io, input logic we);
    logic [3:0] v;
    v = 4'b1111;
    if (cmd) v[3 - {io, we}] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/bsz_wait_ctr.sv
module bsz_wait_ctr #(
  parameter int unsigned WS16    = 1,
  parameter int unsigned WS8     = 4,
  parameter int unsigned TMO_LIM = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic wide_i,
  input  logic zws_ni,
  input  logic rdy_i,
  output logic fin_o,
  output logic tmo_o
);
  localparam int unsigned LEN16 = WS16 + 1;
  localparam int unsigned LEN8  = WS8 + 1;
  localparam int unsigned CW    = $clog2(LEN8 + 1);
  localparam int unsigned EW    = $clog2(TMO_LIM + 1);

  logic [CW-1:0] cnt_q, len;
  logic [EW-1:0] ext_q;
  logic          at_end;

  assign len    = wide_i ? CW'(LEN16) : CW'(LEN8);
  assign at_end = run_i && ((cnt_q >= len) || !zws_ni);
  assign tmo_o  = at_end && !rdy_i && (ext_q == EW'(TMO_LIM - 1));
  assign fin_o  = at_end && (rdy_i || tmo_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(1);
      ext_q <= '0;
    end else if (!run_i || fin_o) begin
      cnt_q <= CW'(1);
      ext_q <= '0;
    end else begin
      if (!at_end) cnt_q <= cnt_q + CW'(1);
      if (at_end && !rdy_i) ext_q <= ext_q + EW'(1);
    end
  end
endmodule

// File: rtl/bsz_lane_steer.sv
module bsz_lane_steer #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W,
  localparam int unsigned SW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          wide_i,
  input  logic [SW-1:0] lane_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic [DW-1:0] rdata_q_i,
  output logic [DW-1:0] bus_wdata_o,
  output logic [DW-1:0] rdata_nxt_o
);
  logic [LANE_W-1:0] sel_byte;
  assign sel_byte = wdata_i[lane_i*LANE_W +: LANE_W];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bus_wdata_o[g*LANE_W +: LANE_W] = wide_i ? wdata_i[g*LANE_W +: LANE_W] : sel_byte;
    assign rdata_nxt_o[g*LANE_W +: LANE_W] =
        wide_i                ? bus_rdata_i[g*LANE_W +: LANE_W] :
        (lane_i == SW'(g))    ? bus_rdata_i[LANE_W-1:0]         :
                                rdata_q_i[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/bsz_seq.sv
module bsz_seq
  import bsz_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    be_i,
  input  logic          we_i,
  input  logic          io_i,
  input  logic          memcs16_ni,
  input  logic          iocs16_ni,
  input  logic          fin_i,
  input  logic          tmo_i,
  output bsz_state_e    state_o,
  output logic          lane_o,
  output logic          wide_o,
  output logic          we_o,
  output logic          io_o,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    be_o,
  output logic          accept_o,
  output logic          capture_o,
  output logic          done_o,
  output logic          err_o
);
  bsz_state_e    state_q;
  logic          lane_q, wide_q, split_q, half2_q, we_q, io_q, done_q, err_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    be_q;
  logic          cs16;
  logic          cmd_end;

  assign cs16      = io_q ? !iocs16_ni : !memcs16_ni;
  assign cmd_end   = (state_q == ST_CMD) && fin_i;
  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = cmd_end && !we_q && !tmo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lane_q  <= 1'b0;
      wide_q  <= 1'b0;
      split_q <= 1'b0;
      half2_q <= 1'b0;
      we_q    <= 1'b0;
      io_q    <= 1'b0;
      addr_q  <= '0;
      be_q    <= 2'b00;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_ADDR;
          addr_q  <= addr_i;
          be_q    <= be_i;
          we_q    <= we_i;
          io_q    <= io_i;
          lane_q  <= (be_i == 2'b10);
          half2_q <= 1'b0;
        end
        ST_ADDR: begin
          state_q <= ST_CMD;
          if (!half2_q) begin
            wide_q  <= cs16;
            split_q <= (be_q == 2'b11) && !cs16;
          end
        end
        ST_CMD: if (fin_i) begin
          if (split_q && !tmo_i) begin
            split_q <= 1'b0;
            half2_q <= 1'b1;
            lane_q  <= 1'b1;
            state_q <= ST_ADDR;
          end else begin
            split_q <= 1'b0;
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= tmo_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign lane_o  = lane_q;
  assign wide_o  = wide_q;
  assign we_o    = we_q;
  assign io_o    = io_q;
  assign addr_o  = addr_q;
  assign be_o    = be_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bsz_pkg::*;
#(
  parameter int unsigned AW      = 24,
  parameter int unsigned WS16    = 1,
  parameter int unsigned WS8     = 4,
  parameter int unsigned TMO_LIM = 8,
  parameter int unsigned LANE_W  = 8,
  localparam int unsigned DW     = 2 * LANE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    be_i,
  input  logic          we_i,
  input  logic          io_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bale_o,
  output logic          bhe_no,
  output logic          mem_rd_no,
  output logic          mem_wr_no,
  output logic          io_rd_no,
  output logic          io_wr_no,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          memcs16_ni,
  input  logic          iocs16_ni,
  input  logic          zws_ni,
  input  logic          rdy_i
);
  bsz_state_e    state;
  logic          lane, wide, we_q, io_q, accept, capture, fin, tmo;
  logic [AW-1:0] addr_q;
  logic [1:0]    be_q;
  logic [DW-1:0] rdata_q, rdata_nxt;

  bsz_seq #(.AW(AW)) i_seq (
    .clk_i, .rst_ni, .req_i, .addr_i, .be_i, .we_i, .io_i,
    .memcs16_ni, .iocs16_ni,
    .fin_i(fin), .tmo_i(tmo),
    .state_o(state), .lane_o(lane), .wide_o(wide), .we_o(we_q), .io_o(io_q),
    .addr_o(addr_q), .be_o(be_q), .accept_o(accept), .capture_o(capture),
    .done_o, .err_o
  );

  bsz_wait_ctr #(.WS16(WS16), .WS8(WS8), .TMO_LIM(TMO_LIM)) i_wait (
    .clk_i, .rst_ni,
    .run_i(state == ST_CMD), .wide_i(wide), .zws_ni, .rdy_i,
    .fin_o(fin), .tmo_o(tmo)
  );

  bsz_lane_steer #(.LANES(2), .LANE_W(LANE_W)) i_steer (
    .wide_i(wide), .lane_i(lane), .wdata_i, .bus_rdata_i, .rdata_q_i(rdata_q),
    .bus_wdata_o, .rdata_nxt_o(rdata_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (accept)  rdata_q <= '0;
    else if (capture) rdata_q <= rdata_nxt;
  end

  assign rdata_o    = rdata_q;
  assign busy_o     = (state != ST_IDLE);
  assign bale_o     = (state == ST_ADDR);
  assign bus_addr_o = {addr_q[AW-1:1], lane};
  assign bhe_no     = !be_q[1];
  assign {mem_rd_no, mem_wr_no, io_rd_no, io_wr_no} = strobe_vec(state == ST_CMD, io_q, we_q);
endmodule

// File: rtl/bsz_chk.sv
module bsz_chk #(
  parameter int unsigned AW      = 24,
  parameter int unsigned WS8     = 4,
  parameter int unsigned TMO_LIM = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bale_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          mem_rd_no,
  input logic          mem_wr_no,
  input logic          io_rd_no,
  input logic          io_wr_no
);
  localparam int unsigned LIM = WS8 + TMO_LIM;
  localparam int unsigned KW  = $clog2(LIM + 2);

  logic [3:0]    act;
  logic [KW-1:0] run_q;
  assign act = ~{mem_rd_no, mem_wr_no, io_rd_no, io_wr_no};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         run_q <= '0;
    else if (act == 4'b0)                run_q <= '0;
    else if (run_q != KW'(LIM + 1))      run_q <= run_q + KW'(1);
  end

  // R10
  a_r10_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(act));
  // R9
  a_r9_no_strobe_in_addr: assert property (@(posedge clk_i) disable iff (!rst_ni) bale_o |-> act == 4'b0);
  a_r9_bale_single: assert property (@(posedge clk_i) disable iff (!rst_ni) bale_o |=> !bale_o && busy_o);
  a_r9_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni) (busy_o && !bale_o) |-> $stable(bus_addr_o));
  // R8
  a_r8_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |-> done_o);
  a_r8_strobe_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni) run_q <= KW'(LIM));
  // R2
  a_r2_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |-> !busy_o);
  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);
endmodule

bind bus_sizer bsz_chk #(.AW(AW), .WS8(WS8), .TMO_LIM(TMO_LIM)) i_bsz_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bale_o(bale_o), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .bus_addr_o(bus_addr_o), .mem_rd_no(mem_rd_no), .mem_wr_no(mem_wr_no),
  .io_rd_no(io_rd_no), .io_wr_no(io_wr_no)
);

// File: tb/test_bus_sizer.sv
`timescale 1ns/1ps
module test_bus_sizer;
  localparam int AW = 24, TMO = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, io = 0;
  logic [AW-1:0] addr = '0;
  logic [1:0] be = 2'b01;
  logic [15:0] wdata = '0, bus_rdata = '0;
  logic memcs16_n = 1, iocs16_n = 1, zws_n = 1, rdy = 1;
  logic busy, done, err, bale, bhe_n, mrd, mwr, iord, iowr;
  logic [15:0] rdata, bus_wdata;
  logic [AW-1:0] bus_addr;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bus_sizer #(.AW(AW), .WS16(1), .WS8(4), .TMO_LIM(TMO)) i_bus_sizer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .be_i(be), .we_i(we), .io_i(io),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .bus_addr_o(bus_addr), .bale_o(bale), .bhe_no(bhe_n), .mem_rd_no(mrd), .mem_wr_no(mwr),
    .io_rd_no(iord), .io_wr_no(iowr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .memcs16_ni(memcs16_n), .iocs16_ni(iocs16_n), .zws_ni(zws_n), .rdy_i(rdy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // behavioural model: expected per-clock timeline built from the requirements
  task automatic run(input string tag, input bit w, input bit o, input logic [AW-1:0] a,
                     input logic [1:0] b, input logic [15:0] wd, input bit c16,
                     input int zi, input int st, input logic [15:0] dev);
    bit split, xerr;
    int nx, base, endp, ncmd;
    logic lane;
    logic [7:0] db;
    logic [3:0] sexp;
    logic [15:0] rexp;
    split = (b == 2'b11) && !c16;
    nx    = split ? 2 : 1;
    base  = c16 ? 2 : 5;
    endp  = (zi > 0 && zi < base) ? zi : base;
    xerr  = (st >= TMO);
    ncmd  = xerr ? endp - 1 + TMO : endp + st;
    sexp  = ~(4'b1000 >> {o, w});
    @(negedge clk);
    req = 1; we = w; io = o; addr = a; be = b; wdata = wd;
    memcs16_n = o ? c16 : !c16;
    iocs16_n  = o ? !c16 : c16;
    @(negedge clk);
    req = 0;
    for (int x = 0; x < nx; x++) begin
      lane = split ? x[0] : (b == 2'b10);
      db   = lane ? dev[15:8] : dev[7:0];
      chk({tag, " R9 bale in address clock"}, bale, 1);
      chk({tag, " R9 no strobe in address clock"}, {mrd, mwr, iord, iowr}, 4'b1111);
      chk({tag, " R4 address"}, bus_addr, {a[AW-1:1], lane});
      chk({tag, " R11 bhe"}, bhe_n, !b[1]);
      @(negedge clk);
      for (int c = 1; c <= ncmd; c++) begin
        chk({tag, " R9 bale low in command"}, bale, 0);
        chk({tag, " R10 strobe"}, {mrd, mwr, iord, iowr}, sexp);
        chk({tag, " R9 address held"}, bus_addr, {a[AW-1:1], lane});
        chk({tag, " R2 no early done"}, done, 0);
        if (w) chk({tag, " R5 write lanes"}, bus_wdata, c16 ? wd : (lane ? {wd[15:8], wd[15:8]} : {wd[7:0], wd[7:0]}));
        rdy       = !(c >= endp && c < endp + st);
        zws_n     = !(zi > 0 && c >= zi);
        bus_rdata = c16 ? dev : {~db, db};
        @(negedge clk);
      end
      rdy = 1; zws_n = 1;
      if (xerr) break;
    end
    chk({tag, " R2 done pulse"}, done, 1);
    chk({tag, " R8 err flag"}, err, xerr);
    chk({tag, " R2 idle at done"}, busy, 0);
    if (!w && !xerr) begin
      rexp = c16 ? dev : split ? dev : ((b == 2'b10) ? {dev[15:8], 8'h00} : {8'h00, dev[7:0]});
      chk({tag, " R5 read data"}, rdata, rexp);
    end
    @(negedge clk);
    chk({tag, " R2 done one clock"}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done/err", {done, err}, 0);
    chk("R1 bale", bale, 0);
    chk("R1 strobes", {mrd, mwr, iord, iowr}, 4'b1111);
    chk("R1 rdata", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after release", {busy, bale}, 0);

    run("R2 word wr mem16",      1, 0, 24'h001234, 2'b11, 16'hBEEF, 1, 0, 0, 16'h0);
    run("R2 word rd io16",       0, 1, 24'h000300, 2'b11, 16'h0,    1, 0, 0, 16'hA55A);
    run("R2 hi byte rd mem16",   0, 0, 24'h0A0011, 2'b10, 16'h0,    1, 0, 0, 16'h1357);
    run("R3 lo byte rd mem8",    0, 0, 24'h0C0002, 2'b01, 16'h0,    0, 0, 0, 16'h7788);
    run("R5 hi byte wr io8",     1, 1, 24'h000379, 2'b10, 16'hC3D4, 0, 0, 0, 16'h0);
    run("R5 hi byte rd io8",     0, 1, 24'h000279, 2'b10, 16'h0,    0, 0, 0, 16'h9A0B);
    run("R4 word rd mem8",       0, 0, 24'h0D0040, 2'b11, 16'h0,    0, 0, 0, 16'hF00D);
    run("R4 word wr io8",        1, 1, 24'h000200, 2'b11, 16'h6B2E, 0, 0, 0, 16'h0);
    run("R6 stall mem16",        0, 0, 24'h100000, 2'b11, 16'h0,    1, 0, 3, 16'h4242);
    run("R6 stall word mem8",    0, 0, 24'h100020, 2'b11, 16'h0,    0, 0, 2, 16'h8421);
    run("R7 zws mem8",           0, 0, 24'h0C8000, 2'b01, 16'h0,    0, 2, 0, 16'h00E7);
    run("R7 zws mem16",          1, 0, 24'h0C8002, 2'b11, 16'h1111, 1, 1, 0, 16'h0);
    run("R7 zws and R6 stall",   0, 1, 24'h000310, 2'b10, 16'h0,    0, 3, 2, 16'h5A00);
    run("R8 timeout mem16",      0, 0, 24'h200000, 2'b11, 16'h0,    1, 0, 20, 16'h0);
    run("R8 timeout split io8",  1, 1, 24'h000330, 2'b11, 16'hABCD, 0, 0, TMO, 16'h0);
    run("R8 limit-1 no timeout", 0, 0, 24'h200010, 2'b01, 16'h0,    0, 0, TMO-1, 16'h00C1);
    run("R2 after timeout",      0, 0, 24'h000100, 2'b11, 16'h0,    1, 0, 0, 16'h2468);
    summary();
  end
endmodule